// File: doc/BRIEF.md
# Periodic Rate Divider with Control

This block turns a 32768 Hz time-base enable into two timing events. The enable advances one shared binary divider chain. A 4-bit rate code picks one stage of that chain. Each time the picked stage rises from 0 to 1, the block raises a one-cycle periodic event. The top stage of the chain gives a one-second tick, which a clock-calendar uses to start its update.

A 3-bit control field sets what the chain does. One code lets it count. A pair of codes keeps the chain cleared while the time base keeps running. Every other code freezes the chain where it is. When the chain leaves the cleared state and starts counting, the first one-second tick comes after half a second. After that, a tick comes every full second.

Top module: `periodic_rate_div`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it goes high, both `per_evt` and `sec_tick` are 0.
- R2: Rate code 0 disables `per_evt`. In the cycle after a clock edge that sampled rate code 0, `per_evt` is 0.
- R3: For rate codes n from 3 to 15, the periodic event repeats every 2^(n-1) time-base ticks. This gives 8192 Hz for code 3 and 2 Hz for code 15.
- R4: Rate code 1 repeats every 128 ticks (256 Hz). Rate code 2 repeats every 256 ticks (128 Hz).
- R5: `per_evt` is high for exactly one cycle. When the chain counts up from zero with period P, the first event appears in the cycle after the (P/2)-th counted tick.
- R6: The chain advances only on clock edges where `tb_en` is 1 and the control code is 010. Both outputs rise only in the cycle after such an edge.
- R7: Control codes 110 and 111 hold the chain at zero. In the cycle after any edge that sampled one of these codes, both outputs are 0.
- R8: When control changes from a hold code (11x) to 010, `sec_tick` pulses for one cycle after the 16384th counted tick. It then pulses every 32768 counted ticks.
- R9: Control codes 000, 001, 011, 100 and 101 freeze the chain: it keeps its count and produces no events. When code 010 returns, counting continues from the frozen count.
- R10: Changing the rate code never disturbs the chain. The timing of `sec_tick` does not depend on how the rate code changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| rate_sel | input | 4 | Selects which chain stage drives the periodic event |
| div_ctl | input | 3 | Chain control: 010 run, 11x hold cleared, any other code freezes |
| per_evt | output | 1 | One-cycle periodic event |
| sec_tick | output | 1 | One-cycle one-second tick |

## Verification
The assertions check, on every cycle, the local rules:
- an event appears only after a counted tick;
- both outputs stay quiet under hold, freeze and rate code 0;
- each pulse lasts a single cycle.

The spacing of events for each rate code, the half-second delay to the first second tick, counting that resumes from a frozen value, and `sec_tick` timing that ignores rate changes all span thousands of cycles. Only the bench scenarios show these, by comparing against a count model cycle by cycle.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [1:0] {
        DIV_STOP = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_HOLD = 2'd2
    } div_mode_e;

    // Control encodings: run on 010, hold cleared on 11x.
    localparam logic [2:0] CTL_RUN_CODE = 3'b010;
    localparam logic [1:0] CTL_HOLD_TOP = 2'b11;

endpackage

// File: rtl/prd_ctl_decode.sv
module prd_ctl_decode
    import prd_pkg::*;
(
    input  logic [2:0] div_ctl,
    output div_mode_e  mode
);

    always_comb begin
        if (div_ctl[2:1] == CTL_HOLD_TOP) begin
            mode = DIV_HOLD;
        end else if (div_ctl == CTL_RUN_CODE) begin
            mode = DIV_RUN;
        end else begin
            mode = DIV_STOP;
        end
    end

endmodule

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
    parameter int SEL_W    = 4,
    parameter int CNT_W    = 15,
    parameter int LOW_TAP  = 6,
    parameter int FAST_OFS = 2
) (
    input  logic [SEL_W-1:0] rate_sel,
    output logic [CNT_W-1:0] tap_mask
);

    // Codes 1..LOW_CODES pick slow taps; higher codes walk the chain upward.
    localparam int LOW_CODES = 2;

    for (genvar k = 0; k < CNT_W; k++) begin : g_tap
        localparam int KI = k;
        logic hit_fast;
        logic hit_low;
        assign hit_fast = (int'(rate_sel) > LOW_CODES) &&
                          (int'(rate_sel) == KI + FAST_OFS);
        assign hit_low  = (int'(rate_sel) >= 1) &&
                          (int'(rate_sel) <= LOW_CODES) &&
                          (KI == LOW_TAP + int'(rate_sel) - 1);
        assign tap_mask[k] = hit_fast || hit_low;
    end

endmodule

// File: rtl/prd_chain.sv
module prd_chain
    import prd_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  div_mode_e        mode,
    output logic [CNT_W-1:0] rise
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chain_s;

    chain_s st_d;
    chain_s st_q;

    always_comb begin
        st_d = st_q;
        rise = '0;
        case (mode)
            DIV_HOLD: st_d.cnt = '0;
            DIV_RUN: begin
                if (tick_en) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    rise     = st_d.cnt & ~st_q.cnt;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div
    import prd_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int SEL_W    = 4,
    parameter int LOW_TAP  = 6,
    parameter int FAST_OFS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [2:0]       div_ctl,
    output logic             per_evt,
    output logic             sec_tick
);

    localparam int SEC_BIT = CNT_W - 1;

    typedef struct packed {
        logic per_evt;
        logic sec_tick;
    } out_s;

    div_mode_e        mode;
    logic [CNT_W-1:0] tap_mask;
    logic [CNT_W-1:0] rise;
    out_s             out_d;
    out_s             out_q;

    prd_ctl_decode u_ctl (
        .div_ctl (div_ctl),
        .mode    (mode)
    );

    prd_rate_decode #(
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W),
        .LOW_TAP  (LOW_TAP),
        .FAST_OFS (FAST_OFS)
    ) u_rate (
        .rate_sel (rate_sel),
        .tap_mask (tap_mask)
    );

    prd_chain #(
        .CNT_W (CNT_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tb_en),
        .mode    (mode),
        .rise    (rise)
    );

    always_comb begin
        out_d          = out_q;
        out_d.per_evt  = |(rise & tap_mask);
        out_d.sec_tick = rise[SEC_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign per_evt  = out_q.per_evt;
    assign sec_tick = out_q.sec_tick;

endmodule

// File: rtl/prd_checks.sv
module prd_checks #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tb_en,
    input logic [SEL_W-1:0] rate_sel,
    input logic [2:0]       div_ctl,
    input logic             per_evt,
    input logic             sec_tick
);

    logic ctl_run;
    logic ctl_hold;
    assign ctl_run  = (div_ctl == 3'b010);
    assign ctl_hold = (div_ctl[2:1] == 2'b11);

    a_r6_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |-> ($past(tb_en) && $past(ctl_run)));

    a_r6_sec_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> ($past(tb_en) && $past(ctl_run)));

    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hold |=> (!per_evt && !sec_tick));

    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_hold && !ctl_run) |=> (!per_evt && !sec_tick));

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !per_evt);

    a_r5_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> !per_evt);

    a_r8_sec_single: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

endmodule

bind periodic_rate_div prd_checks #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .rate_sel (rate_sel),
    .div_ctl  (div_ctl),
    .per_evt  (per_evt),
    .sec_tick (sec_tick)
);

// File: tb/sim_periodic_rate_div.sv
module sim_periodic_rate_div;

    localparam int FULL_TICKS = 32768;
    localparam int HALF_TICKS = 16384;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tb_en;
    logic [3:0] rate_sel;
    logic [2:0] div_ctl;
    logic       per_evt;
    logic       sec_tick;

    always #5 clk = ~clk;

    periodic_rate_div u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_en    (tb_en),
        .rate_sel (rate_sel),
        .div_ctl  (div_ctl),
        .per_evt  (per_evt),
        .sec_tick (sec_tick)
    );

    int    checks = 0;
    int    errors = 0;
    string req    = "R1";
    int    m_cnt  = 0;
    bit    exp_evt = 1'b0;
    bit    exp_sec = 1'b0;

    function automatic int period_of(input logic [3:0] rs);
        if (rs == 4'd0) return 0;
        if (rs == 4'd1) return 128;
        if (rs == 4'd2) return 256;
        return 1 << (int'(rs) - 1);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Predict the upcoming edge from the inputs now applied, then compare.
    task automatic step();
        int p;
        if (!rst_n || div_ctl[2:1] == 2'b11) begin
            m_cnt = 0; exp_evt = 1'b0; exp_sec = 1'b0;
        end else if (div_ctl == 3'b010 && tb_en) begin
            m_cnt   = (m_cnt + 1) % FULL_TICKS;
            p       = period_of(rate_sel);
            exp_evt = (p != 0) && ((m_cnt % p) == p / 2);
            exp_sec = (m_cnt == HALF_TICKS);
        end else begin
            exp_evt = 1'b0; exp_sec = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "per_evt", int'(per_evt), int'(exp_evt));
        chk(req, "sec_tick", int'(sec_tick), int'(exp_sec));
    endtask

    initial begin
        #(190000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n_evt;
        int first_idx;
        int sec_a;
        int sec_b;
        int r;
        bit prev_evt;
        void'($urandom(32'd4242));
        rst_n = 1'b0; tb_en = 1'b1; rate_sel = 4'd3; div_ctl = 3'b010;
        @(negedge clk);
        req = "R1";
        chk("R1", "per_evt in reset", int'(per_evt), 0);
        chk("R1", "sec_tick in reset", int'(sec_tick), 0);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R7: hold codes keep the chain cleared
        req = "R7";
        div_ctl = 3'b110; repeat (20) step();
        div_ctl = 3'b111; repeat (20) step();

        // R3 / R5: fastest code from zero
        req = "R3"; div_ctl = 3'b010; rate_sel = 4'd3;
        n_evt = 0; first_idx = -1; prev_evt = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            step();
            if (per_evt) begin
                n_evt++;
                if (first_idx < 0) first_idx = i;
                if (prev_evt) chk("R5", "back-to-back event", 1, 0);
            end
            prev_evt = per_evt;
        end
        chk("R5", "first event tick index", first_idx, 2);
        chk("R3", "events in 40 ticks", n_evt, 10);
        for (int c = 4; c <= 9; c++) begin
            rate_sel = 4'(c);
            repeat (600) step();
        end

        // R4: the two slow codes
        req = "R4";
        rate_sel = 4'd1; repeat (600) step();
        rate_sel = 4'd2; repeat (600) step();

        // R2: rate code 0
        req = "R2"; rate_sel = 4'd0; repeat (300) step();

        // R9: freeze keeps the count, resume continues from it
        req = "R9"; rate_sel = 4'd3;
        div_ctl = 3'b111; repeat (2) step();
        div_ctl = 3'b010; step();
        div_ctl = 3'b000; repeat (25) step();
        div_ctl = 3'b101; repeat (25) step();
        div_ctl = 3'b010; step();
        chk("R9", "event on first tick after resume", int'(per_evt), 1);

        // R6 / R9 / R7: random gaps, codes and rates
        for (int i = 0; i < 3000; i++) begin
            tb_en = (($urandom % 4) != 0);
            if ((i % 50) == 0) rate_sel = 4'($urandom % 16);
            r = $urandom % 20;
            if (r < 14) begin
                div_ctl = 3'b010; req = "R6";
            end else if (r < 16) begin
                div_ctl = 3'b110 | 3'($urandom % 2); req = "R7";
            end else begin
                case ($urandom % 5)
                    0: div_ctl = 3'b000;
                    1: div_ctl = 3'b001;
                    2: div_ctl = 3'b011;
                    3: div_ctl = 3'b100;
                    default: div_ctl = 3'b101;
                endcase
                req = "R9";
            end
            step();
        end

        // R8 / R10: half-second offset after hold, rate changes ignored
        tb_en = 1'b1; req = "R8";
        div_ctl = 3'b110; repeat (4) step();
        div_ctl = 3'b010; req = "R10";
        sec_a = -1; sec_b = -1;
        for (int i = 1; i <= HALF_TICKS + FULL_TICKS + 8; i++) begin
            if ((i % 1000) == 0) rate_sel = 4'($urandom % 16);
            step();
            if (sec_tick) begin
                if (sec_a < 0) sec_a = i;
                else if (sec_b < 0) sec_b = i;
            end
        end
        chk("R8", "first second tick index", sec_a, HALF_TICKS);
        chk("R8", "second tick index", sec_b, HALF_TICKS + FULL_TICKS);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule